// File: doc/BRIEF.md
# Gated ADSR Envelope Generator

The block produces an 8-bit amplitude envelope for one synthesizer voice. A gate bit starts the attack ramp on its rising edge and starts the release ramp on its falling edge. The attack rate and the decay rate come in as one byte. The sustain level and the release rate come in as a second byte. Every clock counts as one emulated cycle. A free-running 15-bit rate counter is compared with a period picked by the rate nibble of the active phase. Each time the counter reaches that period, one rate tick is produced.

In attack, every rate tick raises the envelope by one. In decay and release, rate ticks pass through a piecewise exponential prescaler, and its divide ratio steps up as the envelope falls. The rate counter is never cleared on a gate change or on a register write. If the period drops below the current count, the next step waits until the counter wraps, which takes roughly 32K cycles. An envelope that falls to zero stays frozen there until the next attack begins. The envelope value drives `env_o` directly, so it can be read back or fed to a multiplier elsewhere.

Top module: `adsr_envelope`

## Requirements
- R1: After reset the envelope is 0x00, the phase is release, the zero freeze is set, the rate counter and prescaler count are 0, and the prescaler ratio is 1.
- R2: The rate nibble picks the step period in cycles from {9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532, 31251}, indexed 0 to 15. The rate counter returns to 0 in the cycle where the count plus one equals the period, and that cycle gives one rate tick.
- R3: When ctrl_we_i is high, gate_i is taken as the new gate. A 0-to-1 change enters attack and clears the zero freeze. A 1-to-0 change enters release. Neither change touches the rate counter.
- R4: When the counter is at or above the period, it keeps counting. After 0x7FFF the next value is 0x0001. Only then can it reach the period, so the next step comes a full wrap later.
- R5: In attack, every rate tick adds one to the envelope (modulo 256) and clears the prescaler count. When the envelope becomes 0xFF, the phase becomes decay.
- R6: In decay, each prescaler step subtracts one from the envelope. Once the envelope equals the sustain nibble times 0x11, it holds there.
- R7: In release, each prescaler step subtracts one from the envelope modulo 256. An envelope of 0x00 with the freeze cleared therefore becomes 0xFF.
- R8: Outside attack, a prescaler step happens on every N-th rate tick. N is set whenever the envelope steps to a threshold value: 0xFF gives 1, 0x5D gives 2, 0x36 gives 4, 0x1A gives 8, 0x0E gives 16, 0x06 gives 30 and 0x00 gives 1.
- R9: When the envelope steps to 0x00, the freeze is set. While frozen, the envelope stays at 0x00 until a gate rising edge occurs.
- R10: A register write takes effect in its own cycle. If the active phase uses the nibble that was written, its period changes at once. A sustain write moves the decay floor at once.
- R11: Byte fields: in ad_data_i, bits 7:4 hold the attack rate and bits 3:0 hold the decay rate. In sr_data_i, bits 7:4 hold the sustain level and bits 3:0 hold the release rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one emulated cycle per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control write strobe, loads gate_i |
| gate_i | input | 1 | Gate bit of the control write |
| ad_we_i | input | 1 | Attack/decay byte write strobe |
| ad_data_i | input | 8 | Attack rate (7:4), decay rate (3:0) |
| sr_we_i | input | 1 | Sustain/release byte write strobe |
| sr_data_i | input | 8 | Sustain level (7:4), release rate (3:0) |
| env_o | output | 8 | Current envelope value |

## Verification
The assertions assume that strobes are clean levels, sampled once per clock, and that reset is held for at least one edge before the first write. The stimulus drives every strobe for one cycle at the falling clock edge, with data stable around the rising edge. Gate pulses are placed so that rising and falling edges land between rate ticks. Stimulus periods are sized so that the full counter wrap of R4 shows up once, in its own phase, after the slow attack rate has pushed the count well past the short period.

// File: rtl/adsr_pkg.sv
package adsr_pkg;
  localparam int NIB_W = 4;
  localparam int ENV_W = 2 * NIB_W;
  localparam int CNT_W = 15;
  localparam int EXP_W = 5;

  typedef enum logic [1:0] {
    ST_ATTACK  = 2'd0,
    ST_DECAY   = 2'd1,
    ST_RELEASE = 2'd2
  } adsr_state_e;

  function automatic logic [CNT_W-1:0] rate_period(input logic [NIB_W-1:0] r);
    logic [CNT_W-1:0] p;
    case (r)
      4'd0:    p = 15'd9;
      4'd1:    p = 15'd32;
      4'd2:    p = 15'd63;
      4'd3:    p = 15'd95;
      4'd4:    p = 15'd149;
      4'd5:    p = 15'd220;
      4'd6:    p = 15'd267;
      4'd7:    p = 15'd313;
      4'd8:    p = 15'd392;
      4'd9:    p = 15'd977;
      4'd10:   p = 15'd1954;
      4'd11:   p = 15'd3126;
      4'd12:   p = 15'd3907;
      4'd13:   p = 15'd11720;
      4'd14:   p = 15'd19532;
      default: p = 15'd31251;
    endcase
    return p;
  endfunction

  // prescaler ratio after the envelope steps to env; other values keep cur
  function automatic logic [EXP_W-1:0] exp_ratio(input logic [ENV_W-1:0] env,
                                                 input logic [EXP_W-1:0] cur);
    logic [EXP_W-1:0] n;
    case (env)
      8'hff:   n = 5'd1;
      8'h5d:   n = 5'd2;
      8'h36:   n = 5'd4;
      8'h1a:   n = 5'd8;
      8'h0e:   n = 5'd16;
      8'h06:   n = 5'd30;
      8'h00:   n = 5'd1;
      default: n = cur;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/adsr_regs.sv
module adsr_regs
  import adsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             gate_i,
  input  logic             ad_we_i,
  input  logic [ENV_W-1:0] ad_data_i,
  input  logic             sr_we_i,
  input  logic [ENV_W-1:0] sr_data_i,
  output logic [NIB_W-1:0] attack_o,
  output logic [NIB_W-1:0] decay_o,
  output logic [NIB_W-1:0] sustain_o,
  output logic [NIB_W-1:0] release_o,
  output logic             gate_rise_o,
  output logic             gate_fall_o
);
  logic             gate_q, gate_d;
  logic [ENV_W-1:0] ad_q, sr_q, ad_d, sr_d;

  // write values are visible in the cycle of the write
  assign gate_d = ctrl_we_i ? gate_i : gate_q;
  assign ad_d   = ad_we_i ? ad_data_i : ad_q;
  assign sr_d   = sr_we_i ? sr_data_i : sr_q;

  assign attack_o    = ad_d[ENV_W-1:NIB_W];
  assign decay_o     = ad_d[NIB_W-1:0];
  assign sustain_o   = sr_d[ENV_W-1:NIB_W];
  assign release_o   = sr_d[NIB_W-1:0];
  assign gate_rise_o = gate_d & ~gate_q;
  assign gate_fall_o = ~gate_d & gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      ad_q   <= '0;
      sr_q   <= '0;
    end else begin
      gate_q <= gate_d;
      ad_q   <= ad_d;
      sr_q   <= sr_d;
    end
  end
endmodule

// File: rtl/adsr_rate_timer.sv
module adsr_rate_timer
  import adsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign tick_o  = (cnt_inc == {1'b0, period_i});

  always_comb begin
    if (tick_o)      cnt_d = '0;
    else if (&cnt_q) cnt_d = CNT_W'(1);  // wrap skips zero
    else             cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adsr_exp_prescaler.sv
module adsr_exp_prescaler
  import adsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bypass_i,
  input  logic             load_i,
  input  logic [ENV_W-1:0] env_next_i,
  output logic             advance_o,
  output logic [EXP_W-1:0] cnt_o,
  output logic [EXP_W-1:0] ratio_o
);
  logic [EXP_W-1:0] cnt_q, ratio_q;
  logic [EXP_W-1:0] cnt_inc;

  assign cnt_inc   = cnt_q + 1'b1;
  assign advance_o = tick_i & (bypass_i | (cnt_inc == ratio_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= EXP_W'(1);
    end else begin
      if (advance_o)   cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_inc;
      if (load_i)      ratio_q <= exp_ratio(env_next_i, ratio_q);
    end
  end

  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/adsr_level_core.sv
module adsr_level_core
  import adsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_rise_i,
  input  logic             gate_fall_i,
  input  logic [NIB_W-1:0] sustain_i,
  input  logic             advance_i,
  output adsr_state_e      state_w_o,
  output adsr_state_e      state_q_o,
  output logic             hold_q_o,
  output logic             load_o,
  output logic [ENV_W-1:0] env_next_o,
  output logic [ENV_W-1:0] env_o
);
  adsr_state_e      state_q, state_w, state_d;
  logic             hold_q, hold_w, hold_d;
  logic [ENV_W-1:0] env_q, env_d, floor_lvl;

  assign floor_lvl = {sustain_i, sustain_i};
  assign state_w   = gate_rise_i ? ST_ATTACK : (gate_fall_i ? ST_RELEASE : state_q);
  assign hold_w    = gate_rise_i ? 1'b0 : hold_q;
  assign load_o    = advance_i & ~hold_w;

  always_comb begin
    env_d   = env_q;
    state_d = state_w;
    hold_d  = hold_w;
    if (load_o) begin
      case (state_w)
        ST_ATTACK: begin
          env_d = env_q + 1'b1;
          if (&env_d) state_d = ST_DECAY;
        end
        ST_DECAY:   if (env_q != floor_lvl) env_d = env_q - 1'b1;
        default:    env_d = env_q - 1'b1;
      endcase
      if (env_d == '0) hold_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RELEASE;
      hold_q  <= 1'b1;
      env_q   <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      env_q   <= env_d;
    end
  end

  assign state_w_o  = state_w;
  assign state_q_o  = state_q;
  assign hold_q_o   = hold_q;
  assign env_next_o = env_d;
  assign env_o      = env_q;
endmodule

// File: rtl/adsr_envelope.sv
module adsr_envelope
  import adsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             gate_i,
  input  logic             ad_we_i,
  input  logic [ENV_W-1:0] ad_data_i,
  input  logic             sr_we_i,
  input  logic [ENV_W-1:0] sr_data_i,
  output logic [ENV_W-1:0] env_o
);
  logic [NIB_W-1:0] attack_eff, decay_eff, sustain_eff, release_eff, rate_sel;
  logic             gate_rise, gate_fall, rate_tick, advance, load, hold_q;
  logic [CNT_W-1:0] rate_cnt;
  logic [EXP_W-1:0] exp_cnt, exp_per;
  logic [ENV_W-1:0] env_next;
  adsr_state_e      state_w, state_q;

  adsr_regs u_regs (
    .clk_i, .rst_ni, .ctrl_we_i, .gate_i, .ad_we_i, .ad_data_i, .sr_we_i, .sr_data_i,
    .attack_o(attack_eff), .decay_o(decay_eff), .sustain_o(sustain_eff),
    .release_o(release_eff), .gate_rise_o(gate_rise), .gate_fall_o(gate_fall)
  );

  always_comb begin
    case (state_w)
      ST_ATTACK: rate_sel = attack_eff;
      ST_DECAY:  rate_sel = decay_eff;
      default:   rate_sel = release_eff;
    endcase
  end

  adsr_rate_timer u_timer (
    .clk_i, .rst_ni, .period_i(rate_period(rate_sel)), .tick_o(rate_tick), .cnt_o(rate_cnt)
  );

  adsr_exp_prescaler u_exp (
    .clk_i, .rst_ni, .tick_i(rate_tick), .bypass_i(state_w == ST_ATTACK), .load_i(load),
    .env_next_i(env_next), .advance_o(advance), .cnt_o(exp_cnt), .ratio_o(exp_per)
  );

  adsr_level_core u_core (
    .clk_i, .rst_ni, .gate_rise_i(gate_rise), .gate_fall_i(gate_fall),
    .sustain_i(sustain_eff), .advance_i(advance), .state_w_o(state_w),
    .state_q_o(state_q), .hold_q_o(hold_q), .load_o(load),
    .env_next_o(env_next), .env_o(env_o)
  );
endmodule

// File: rtl/adsr_envelope_chk.sv
module adsr_envelope_chk
  import adsr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ENV_W-1:0] env_o,
  input adsr_state_e      state_q,
  input logic             hold_q,
  input logic             gate_rise,
  input logic             gate_fall,
  input logic [NIB_W-1:0] sustain_eff,
  input logic [CNT_W-1:0] rate_cnt,
  input logic [EXP_W-1:0] exp_cnt,
  input logic [EXP_W-1:0] exp_per
);
  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (env_o != $past(env_o)) |->
      (env_o == ENV_W'($past(env_o) + 1'b1)) || (env_o == ENV_W'($past(env_o) - 1'b1))); // R5

  AST_FROZEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !gate_rise) |=> (env_o == '0)); // R9

  AST_SUSTAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECAY && !gate_rise && !gate_fall && env_o == {sustain_eff, sustain_eff})
      |=> $stable(env_o)); // R6

  AST_WRAP_SKIPS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&rate_cnt) |=> (rate_cnt == CNT_W'(1))); // R4

  AST_EXP_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_cnt < exp_per); // R8

  AST_FALL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_fall |=> (state_q == ST_RELEASE)); // R3

  AST_RISE_LEAVES_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_rise |=> (state_q != ST_RELEASE)); // R3
endmodule

bind adsr_envelope adsr_envelope_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .env_o(env_o), .state_q(state_q), .hold_q(hold_q),
  .gate_rise(gate_rise), .gate_fall(gate_fall), .sustain_eff(sustain_eff),
  .rate_cnt(rate_cnt), .exp_cnt(exp_cnt), .exp_per(exp_per)
);

// File: tb/sim_adsr_envelope.sv
`timescale 1ns/1ps
module sim_adsr_envelope;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0, gate_i = 1'b0;
  logic       ad_we_i = 1'b0, sr_we_i = 1'b0;
  logic [7:0] ad_data_i = 8'h00, sr_data_i = 8'h00;
  logic [7:0] env_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit fin = 1'b0;
  string phase = "R1 reset";

  always #10 clk_i = ~clk_i;

  adsr_envelope u0 (.*);

  // behavioural reference, one emulated cycle per clock
  int per_tab[16] = '{9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907,
                      11720, 19532, 31251};
  int m_env, m_state, m_hold, m_rc, m_ec, m_ep, m_gate, m_a, m_d, m_s, m_r;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_env = 0; m_state = 2; m_hold = 1; m_rc = 0; m_ec = 0; m_ep = 1;
      m_gate = 0; m_a = 0; m_d = 0; m_s = 0; m_r = 0;
    end else begin
      int per, stp, adv;
      if (ad_we_i) begin m_a = ad_data_i[7:4]; m_d = ad_data_i[3:0]; end
      if (sr_we_i) begin m_s = sr_data_i[7:4]; m_r = sr_data_i[3:0]; end
      if (ctrl_we_i) begin
        if (!m_gate && gate_i) begin m_state = 0; m_hold = 0; end
        else if (m_gate && !gate_i) m_state = 2;
        m_gate = gate_i;
      end
      per = per_tab[m_state == 0 ? m_a : (m_state == 1 ? m_d : m_r)];
      stp = per - m_rc;
      if (stp <= 0) stp += 32767;
      if (stp > 1) begin
        m_rc++;
        if (m_rc >= 32768) m_rc = (m_rc + 1) % 32768;
      end else begin
        m_rc = 0;
        if (m_state == 0) adv = 1;
        else begin m_ec++; adv = (m_ec == m_ep); end
        if (adv) begin
          m_ec = 0;
          if (!m_hold) begin
            if (m_state == 0) begin
              m_env = (m_env + 1) % 256;
              if (m_env == 255) m_state = 1;
            end else if (m_state == 1) begin
              if (m_env != m_s * 17) m_env--;
            end else m_env = (m_env + 255) % 256;
            case (m_env)
              255: m_ep = 1;
              93:  m_ep = 2;
              54:  m_ep = 4;
              26:  m_ep = 8;
              14:  m_ep = 16;
              6:   m_ep = 30;
              0:   begin m_ep = 1; m_hold = 1; end
              default: ;
            endcase
          end
        end
      end
    end
  end

  // cycle compare against the reference
  always @(negedge clk_i) begin
    if (rst_ni && !fin) begin
      n_chk++;
      if (env_o !== m_env[7:0]) begin
        n_fail++;
        $display("FAIL %s: env_o=%0h expected %0h", phase, env_o, m_env[7:0]);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000 && !fin) begin
      fin = 1'b1;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk_i); ctrl_we_i = 1'b1; gate_i = v;
    @(negedge clk_i); ctrl_we_i = 1'b0;
  endtask

  task automatic wr_ad(input logic [7:0] v);
    @(negedge clk_i); ad_we_i = 1'b1; ad_data_i = v;
    @(negedge clk_i); ad_we_i = 1'b0;
  endtask

  task automatic wr_sr(input logic [7:0] v);
    @(negedge clk_i); sr_we_i = 1'b1; sr_data_i = v;
    @(negedge clk_i); sr_we_i = 1'b0;
  endtask

  task automatic wait_env(input logic [7:0] v, input int lim, output int n);
    n = 0;
    while (env_o != v && n < lim) begin @(negedge clk_i); n++; end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(env_o == 8'h00, "R1 envelope after reset", env_o, 0);
    repeat (40) @(negedge clk_i);
    chk(env_o == 8'h00, "R1 R9 frozen release after reset", env_o, 0);

    wr_sr(8'h80);
    wr_ad(8'h00);
    phase = "R3 R5 attack";
    set_gate(1'b1);
    wait_env(8'h01, 100, n);
    wait_env(8'h02, 100, n);
    chk(n == 9, "R2 attack step interval rate 0", n, 9);
    wait_env(8'hff, 3000, n);
    chk(env_o == 8'hff, "R5 attack reaches ff", env_o, 8'hff);
    wait_env(8'hfe, 100, n);
    chk(n == 9, "R5 R6 decay follows ff", n, 9);

    phase = "R6 decay";
    repeat (1500) @(negedge clk_i);
    chk(env_o == 8'h88, "R6 R11 sustain nibble 8 floor", env_o, 8'h88);
    repeat (300) @(negedge clk_i);
    chk(env_o == 8'h88, "R6 floor held", env_o, 8'h88);

    phase = "R10 sustain rewrite";
    wr_sr(8'h40);
    repeat (1500) @(negedge clk_i);
    chk(env_o == 8'h44, "R10 new floor applied", env_o, 8'h44);

    phase = "R7 R8 release";
    set_gate(1'b0);
    wait_env(8'h30, 3000, n);
    wait_env(8'h2f, 200, n);
    chk(n == 36, "R8 ratio 4 below 0x36", n, 36);
    wait_env(8'h0a, 4000, n);
    wait_env(8'h09, 400, n);
    chk(n == 144, "R8 ratio 16 below 0x0e", n, 144);
    wait_env(8'h00, 4000, n);
    chk(env_o == 8'h00, "R9 release reaches zero", env_o, 0);
    repeat (3000) @(negedge clk_i);
    chk(env_o == 8'h00, "R9 zero stays frozen", env_o, 0);

    phase = "R3 R7 wrap below zero";
    set_gate(1'b1);
    set_gate(1'b0);
    n = 0;
    while (env_o == 8'h00 && n < 40000) begin @(negedge clk_i); n++; end
    chk(env_o == 8'hff, "R3 R7 unfrozen release wraps to ff", env_o, 8'hff);
    wait_env(8'h00, 9000, n);

    phase = "R4 counter wrap";
    wr_ad(8'hf0);
    set_gate(1'b1);
    repeat (500) @(negedge clk_i);
    chk(env_o == 8'h00, "R4 slow attack not stepped", env_o, 0);
    wr_ad(8'h00);
    repeat (30000) @(negedge clk_i);
    chk(env_o == 8'h00, "R4 R10 short period waits for wrap", env_o, 0);
    wait_env(8'h01, 4000, n);
    chk(env_o == 8'h01, "R4 step after wrap", env_o, 1);

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule